// File: doc/BRIEF.md
# Codec Register Command Port

This block is the host-side port through which software reads and writes the registers of up to four audio codecs on a shared serial link. Software first loads a 16-bit data register when it wants a write. It then writes a command word that holds the target codec, the direction and the register index. Accepting the command starts one transaction toward the link side. The link side sees a request with the decoded fields and answers with a single-cycle acknowledge, which carries the read data when the transaction is a read.

While a transaction is in flight the status word reports busy. Software may not start another command until busy drops. A command written while busy is discarded and raises a sticky collision flag. A completed read leaves its result in the data register and sets a data-valid flag, which the next accepted command clears. The port also holds two reset control bits that drive the codec cold-reset and warm-reset lines directly.

The sequencer is a two-state machine. In IDLE it waits for a command write; the transition IDLE to WAIT is named LAUNCH. In WAIT it holds the link request until acknowledge; the transition WAIT to IDLE is named RETIRE. Every other case keeps the current state.

Top module: `codec_cmd_port`

## Requirements
- R1: After reset, the status word, data register and control register all read 0, link_req is 0, and both codec reset outputs are 0.
- R2: A write to the command word (reg_sel 0) while not busy starts a transaction. From the next cycle, status bit 9 (busy) and link_req are 1. link_idx carries command bits 6:0, link_rd carries bit 7 (1 = read, 0 = write), and link_id carries bits 11:10. The status word echoes these fields at the same bit positions.
- R3: For a write transaction, link_wdata carries the value placed in the data register (reg_sel 1) before the command word was written.
- R4: link_req and its fields stay unchanged until link_ack is sampled high. Busy and link_req are 0 in the cycle after that acknowledge.
- R5: For a read, the acknowledge cycle loads link_rdata into the data register. Status bit 8 (data valid) rises at the same edge at which busy falls. A write transaction never sets bit 8.
- R6: An accepted command word clears status bit 8 from the next cycle.
- R7: A command word written while busy is ignored: the request fields do not change and no extra transaction follows. It sets status bit 12 (collision). That bit stays set until a control write (reg_sel 2) with bit 0 = 1 clears it.
- R8: A data register write while busy is ignored; data_rd and link_wdata keep their value.
- R9: A control write stores bit 5 and bit 6 into the control register. cold_rst follows bit 5 and warm_rst follows bit 6 from the next cycle, each active while 1. ctrl_rd returns only those two bits.
- R10: link_ack while not busy has no effect on the data register, the status word or the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Software register write strobe |
| reg_sel | input | 2 | Register select: 0 command, 1 data, 2 control |
| reg_wdata | input | 16 | Software write data |
| cmd_status | output | 16 | Command/status word readback |
| data_rd | output | DATA_W | Data register readback |
| ctrl_rd | output | 16 | Control register readback |
| link_req | output | 1 | Transaction request toward the link |
| link_rd | output | 1 | Request direction, 1 = read |
| link_id | output | 2 | Target codec id |
| link_idx | output | 7 | Target codec register index |
| link_wdata | output | DATA_W | Write data for the request |
| link_ack | input | 1 | Link side completion strobe |
| link_rdata | input | DATA_W | Read data valid with link_ack |
| cold_rst | output | 1 | Codec cold reset, active high |
| warm_rst | output | 1 | Codec warm reset, active high |

## Verification
A sequencer stuck in WAIT would show as a busy bit and a link request that never drop after an acknowledge. A sequencer that skipped WAIT would show as a missing request one cycle after the command write. Either is visible at the ports within one cycle. A wrong flag update would show at the next status read: a lost collision bit, a valid bit left set by a new command, or valid set after a write. The bench compares the whole status word against its model on every cycle, so the mismatch is reported in the cycle it arises.

// File: rtl/codec_port_pkg.sv
package codec_port_pkg;

    localparam int CMD_W   = 16;
    localparam int IDX_W   = 7;
    localparam int ID_W    = 2;

    localparam int POS_RD   = 7;
    localparam int POS_VAL  = 8;
    localparam int POS_BUSY = 9;
    localparam int POS_ID   = 10;
    localparam int POS_ERR  = 12;
    localparam int POS_COLD = 5;
    localparam int POS_WARM = 6;
    localparam int POS_ECLR = 0;

    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } port_state_e;

    typedef struct packed {
        logic [ID_W-1:0]  id;
        logic             rd;
        logic [IDX_W-1:0] idx;
    } cmd_fields_t;

endpackage

// File: rtl/codec_cmd_fsm.sv
module codec_cmd_fsm
    import codec_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic link_ack,
    output logic busy,
    output logic retire
);

    port_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch)   state_d = ST_WAIT;
            ST_WAIT: if (link_ack) state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        busy   = 1'b0;
        retire = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WAIT: begin
                busy   = 1'b1;
                retire = link_ack;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/codec_cmd_regs.sv
module codec_cmd_regs
    import codec_port_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              retire,
    input  logic              cmd_wr,
    input  logic              data_wr,
    input  logic              ctrl_wr,
    input  logic [CMD_W-1:0]  wdata,
    input  logic [DATA_W-1:0] link_rdata,
    output logic              launch,
    output cmd_fields_t       cmd_q,
    output logic [DATA_W-1:0] data_q,
    output logic              valid_q,
    output logic              err_q,
    output logic              cold_q,
    output logic              warm_q
);

    cmd_fields_t cmd_in;
    logic        collide;

    assign cmd_in.idx = wdata[IDX_W-1:0];
    assign cmd_in.rd  = wdata[POS_RD];
    assign cmd_in.id  = wdata[POS_ID +: ID_W];

    assign launch  = cmd_wr && !busy;
    assign collide = cmd_wr &&  busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
            cold_q  <= 1'b0;
            warm_q  <= 1'b0;
        end else begin
            if (launch) begin
                cmd_q   <= cmd_in;
                valid_q <= 1'b0;
            end
            if (retire && cmd_q.rd) begin
                data_q  <= link_rdata;
                valid_q <= 1'b1;
            end else if (data_wr && !busy) begin
                data_q  <= wdata[DATA_W-1:0];
            end
            if (ctrl_wr) begin
                cold_q <= wdata[POS_COLD];
                warm_q <= wdata[POS_WARM];
                if (wdata[POS_ECLR]) err_q <= 1'b0;
            end
            if (collide) err_q <= 1'b1;
        end
    end

endmodule

// File: rtl/codec_cmd_port.sv
module codec_cmd_port
    import codec_port_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       cmd_status,
    output logic [DATA_W-1:0] data_rd,
    output logic [15:0]       ctrl_rd,
    output logic              link_req,
    output logic              link_rd,
    output logic [1:0]        link_id,
    output logic [6:0]        link_idx,
    output logic [DATA_W-1:0] link_wdata,
    input  logic              link_ack,
    input  logic [DATA_W-1:0] link_rdata,
    output logic              cold_rst,
    output logic              warm_rst
);

    logic        busy, retire, launch;
    logic        valid_q, err_q, cold_q, warm_q;
    cmd_fields_t cmd_q;
    logic [DATA_W-1:0] data_q;

    logic cmd_wr, data_wr, ctrl_wr;
    assign cmd_wr  = reg_wr && (reg_sel == SEL_CMD);
    assign data_wr = reg_wr && (reg_sel == SEL_DATA);
    assign ctrl_wr = reg_wr && (reg_sel == SEL_CTRL);

    codec_cmd_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .link_ack (link_ack),
        .busy     (busy),
        .retire   (retire)
    );

    codec_cmd_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .retire     (retire),
        .cmd_wr     (cmd_wr),
        .data_wr    (data_wr),
        .ctrl_wr    (ctrl_wr),
        .wdata      (reg_wdata),
        .link_rdata (link_rdata),
        .launch     (launch),
        .cmd_q      (cmd_q),
        .data_q     (data_q),
        .valid_q    (valid_q),
        .err_q      (err_q),
        .cold_q     (cold_q),
        .warm_q     (warm_q)
    );

    always_comb begin
        cmd_status                     = '0;
        cmd_status[IDX_W-1:0]          = cmd_q.idx;
        cmd_status[POS_RD]             = cmd_q.rd;
        cmd_status[POS_VAL]            = valid_q;
        cmd_status[POS_BUSY]           = busy;
        cmd_status[POS_ID +: ID_W]     = cmd_q.id;
        cmd_status[POS_ERR]            = err_q;
        ctrl_rd                        = '0;
        ctrl_rd[POS_COLD]              = cold_q;
        ctrl_rd[POS_WARM]              = warm_q;
    end

    assign data_rd    = data_q;
    assign link_req   = busy;
    assign link_rd    = cmd_q.rd;
    assign link_id    = cmd_q.id;
    assign link_idx   = cmd_q.idx;
    assign link_wdata = data_q;
    assign cold_rst   = cold_q;
    assign warm_rst   = warm_q;

endmodule

// File: rtl/codec_cmd_port_chk.sv
module codec_cmd_port_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [1:0]        reg_sel,
    input logic [15:0]       reg_wdata,
    input logic [15:0]       cmd_status,
    input logic [DATA_W-1:0] data_rd,
    input logic [15:0]       ctrl_rd,
    input logic              link_req,
    input logic              link_rd,
    input logic [1:0]        link_id,
    input logic [6:0]        link_idx,
    input logic [DATA_W-1:0] link_wdata,
    input logic              link_ack,
    input logic [DATA_W-1:0] link_rdata,
    input logic              cold_rst,
    input logic              warm_rst
);

    p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd0 && !link_req) |=>
            (link_req && link_idx == $past(reg_wdata[6:0]) && link_rd == $past(reg_wdata[7])));

    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (link_req && !link_ack) |=>
            (link_req && $stable(link_idx) && $stable(link_id) && $stable(link_rd)));

    p_retire_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (link_req && link_ack) |=> !link_req);

    p_read_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (link_req && link_ack && link_rd) |=>
            (cmd_status[8] && !cmd_status[9] && data_rd == $past(link_rdata)));

    p_clear_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd0 && !link_req) |=> !cmd_status[8]);

    p_collide_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd0 && link_req) |=> (cmd_status[12] && $stable(link_idx)));

    p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd1 && link_req && !link_ack) |=> $stable(data_rd));

    p_reset_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd2) |=>
            (cold_rst == $past(reg_wdata[5]) && warm_rst == $past(reg_wdata[6])));

    p_idle_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_req && link_ack && !reg_wr) |=> ($stable(data_rd) && $stable(cmd_status)));

endmodule

bind codec_cmd_port codec_cmd_port_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/codec_cmd_port_tb.sv
module codec_cmd_port_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_sel = 2'd0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   cmd_status, ctrl_rd;
    logic [DW-1:0] data_rd, link_wdata;
    logic          link_req, link_rd, cold_rst, warm_rst;
    logic [1:0]    link_id;
    logic [6:0]    link_idx;
    logic          link_ack = 1'b0;
    logic [DW-1:0] link_rdata = '0;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    codec_cmd_port #(.DATA_W(DW)) dut_i (.*);

    // behavioural reference model
    int m_busy, m_valid, m_err, m_cold, m_warm, m_rd, m_id, m_idx, m_data;

    always @(posedge clk) begin
        int ob;
        if (!rst_n) begin
            m_busy = 0; m_valid = 0; m_err = 0; m_cold = 0; m_warm = 0;
            m_rd = 0; m_id = 0; m_idx = 0; m_data = 0;
        end else begin
            ob = m_busy;
            if (ob != 0 && link_ack) begin
                m_busy = 0;
                if (m_rd != 0) begin m_data = int'(link_rdata); m_valid = 1; end
            end
            if (reg_wr && reg_sel == 2'd0) begin
                if (ob != 0) m_err = 1;
                else begin
                    m_idx = int'(reg_wdata) % 128;
                    m_rd  = (int'(reg_wdata) / 128) % 2;
                    m_id  = (int'(reg_wdata) / 1024) % 4;
                    m_busy = 1; m_valid = 0;
                end
            end
            if (reg_wr && reg_sel == 2'd1 && ob == 0) m_data = int'(reg_wdata);
            if (reg_wr && reg_sel == 2'd2) begin
                m_cold = reg_wdata[5];
                m_warm = reg_wdata[6];
                if (reg_wdata[0]) m_err = 0;
            end
        end
    end

    function automatic int exp_status();
        return m_idx + m_rd*128 + m_valid*256 + m_busy*512 + m_id*1024 + m_err*4096;
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2/R5/R6/R7 status", int'(cmd_status), exp_status());
            check("R3/R5/R8 data", int'(data_rd), m_data);
            check("R4 link_req", int'(link_req), m_busy);
            check("R9 ctrl", int'(ctrl_rd), m_cold*32 + m_warm*64);
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic ack(input logic [15:0] rd);
        link_ack = 1'b1; link_rdata = rd;
        @(negedge clk);
        link_ack = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        idle(2);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 status", int'(cmd_status), 0);
        check("R1 data", int'(data_rd), 0);
        check("R1 req", int'(link_req), 0);
        check("R1 resets", int'({cold_rst, warm_rst}), 0);

        // write transaction: data first, then command id 2 index 0x26
        wr(2'd1, 16'hBEEF);
        wr(2'd0, 16'h0826);
        check("R2 req", int'(link_req), 1);
        check("R2 id", int'(link_id), 2);
        check("R2 idx", int'(link_idx), 'h26);
        check("R2 dir", int'(link_rd), 0);
        check("R3 wdata", int'(link_wdata), 'hBEEF);
        idle(2);
        check("R4 hold", int'(link_req), 1);
        wr(2'd1, 16'h1111);
        check("R8 data kept", int'(link_wdata), 'hBEEF);
        ack(16'h7777);
        check("R4 retire", int'(cmd_status[9]), 0);
        check("R5 no valid on write", int'(cmd_status[8]), 0);
        check("R5 data unchanged on write", int'(data_rd), 'hBEEF);

        // read transaction id 1 index 0x7C
        wr(2'd0, 16'h04FC);
        check("R2 read dir", int'(link_rd), 1);
        idle(1);
        ack(16'h5A5A);
        check("R5 valid", int'(cmd_status[8]), 1);
        check("R5 busy", int'(cmd_status[9]), 0);
        check("R5 data", int'(data_rd), 'h5A5A);

        // R10: stray acknowledge while idle
        ack(16'hFFFF);
        check("R10 data", int'(data_rd), 'h5A5A);
        check("R10 req", int'(link_req), 0);

        // R6 and R7
        wr(2'd0, 16'h0083);
        check("R6 valid cleared", int'(cmd_status[8]), 0);
        wr(2'd0, 16'h0C01);
        check("R7 idx kept", int'(link_idx), 3);
        check("R7 error", int'(cmd_status[12]), 1);
        ack(16'h1234);
        check("R7 no extra", int'(link_req), 0);
        idle(2);
        check("R7 sticky", int'(cmd_status[12]), 1);
        wr(2'd2, 16'h0001);
        check("R7 cleared", int'(cmd_status[12]), 0);

        // R9: reset control bits
        wr(2'd2, 16'h0020);
        check("R9 cold", int'({cold_rst, warm_rst}), 2);
        wr(2'd2, 16'h0040);
        check("R9 warm", int'({cold_rst, warm_rst}), 1);
        wr(2'd2, 16'hFF9E);
        check("R9 only two bits", int'(ctrl_rd), 0);

        // back-to-back reads
        for (int k = 0; k < 4; k++) begin
            wr(2'd0, 16'(16'h0080 | (k << 10) | k));
            ack(16'(16'hA000 + k));
            check("R5 loop data", int'(data_rd), 'hA000 + k);
        end

        idle(2);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule